// File: doc/BRIEF.md
# Modem status and interrupt register

This block holds the 16-bit status word of a serial receiver peripheral and produces its interrupt. The receive path sends single-cycle event pulses in the register's own clock domain: a character or byte is ready, the data register overflowed, a framing or FCS check failed, an HDLC packet ended. Each pulse sets a sticky flag. In start-stop mode, each ready event also loads parity and two-character information. A host reads the status word and the receive data register through read strobes. Those strobes clear the flags that belong to them.

A 16-bit control word, written by the host, holds the interrupt masks, a reset bit, a powersave bit and an enable for the interrupt pin. The interrupt flag (status bit 15) latches only when a masked status bit goes from 0 to 1. Several host actions clear it. A ring-detect pin, active low, passes through a two-flop synchronizer. Status bit 14 shows the pin inverted, and it keeps working while the control word holds the block in reset or powersave.

Top module: `modem_status_irq`

## Requirements
- R1: After the synchronous reset `rst`, `stat_word` and `ctrl_word` read 0x0000 and `irq_n` is 1, with the ring pin idle high.
- R2: Status bit 6 (data ready) sets one cycle after an `ev_ready` pulse and clears after an `rxd_rd` strobe. When `ev_ready` arrives in the same cycle as `rxd_rd`, the bit stays set.
- R3: Status bit 5 (overrun) sets one cycle after an `ev_overrun` pulse and clears after `rxd_rd`. A same-cycle event wins over the clear.
- R4: Status bit 4 (receive error) sets one cycle after an `ev_error` pulse and clears after a `stat_rd` strobe. A same-cycle event wins over the clear.
- R5: With `hdlc_mode` = 0, every `ev_ready` pulse loads three bits: bit 3 = `par1_even`, bit 2 = `par2_even` AND `two_char`, and bit 1 = `two_char`. These bits hold until the next `ev_ready`.
- R6: With `hdlc_mode` = 1, bit 3 sets on an `ev_eop` pulse and clears after `rxd_rd`, and bits 2 and 1 read 0.
- R7: Bit 15 (IRQ) sets in the same cycle as one of three 0-to-1 transitions: bit 6 while control bit 0 is 1, bit 5 while control bit 1 is 1, or bit 14 while control bits 5 and 6 are both 1. No other transition sets it.
- R8: Bit 15 clears after a `stat_rd` strobe, unless a setting transition happens in the same cycle. It also clears after `cmd_reset`, and after a control write with bit 7 or bit 8 at 1. These last two clears win over a same-cycle setting transition.
- R9: `irq_n` is 0 exactly when status bit 15 and control bit 6 are both 1.
- R10: Bit 14 shows the inverted level of `ring_det_n` two clock edges after the pin changes. This holds regardless of control bits 7 and 8 and of `cmd_reset`.
- R11: While control bit 7 (reset) or bit 8 (powersave) is 1, receive event pulses are ignored and bits 6 to 1 read 0 from the following cycle on.
- R12: `cmd_reset` clears the control word, bits 6 to 1 and bit 15 at the next edge, and has priority over a same-cycle control write.
- R13: `stat_word` always shows the value from before any clear, so a read strobe changes it only at the following edge. Bits 13 to 7 and bit 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_det_n | input | 1 | Asynchronous ring-detect pin, active low |
| hdlc_mode | input | 1 | 1 selects packet (HDLC) flag meaning, 0 selects start-stop |
| ev_ready | input | 1 | Pulse: receive data loaded into the data register |
| ev_overrun | input | 1 | Pulse: receive data overflow |
| ev_error | input | 1 | Pulse: framing error or FCS error |
| ev_eop | input | 1 | Pulse: final FCS byte of a packet received |
| par1_even | input | 1 | Even parity of the first character, valid with `ev_ready` |
| par2_even | input | 1 | Even parity of the second character, valid with `ev_ready` |
| two_char | input | 1 | Data register holds two characters, valid with `ev_ready` |
| stat_rd | input | 1 | Host read strobe for the status word |
| rxd_rd | input | 1 | Host read strobe for the receive data register |
| ctrl_we | input | 1 | Host write strobe for the control word |
| ctrl_wdata | input | 16 | Control word write data |
| cmd_reset | input | 1 | General reset command pulse |
| stat_word | output | 16 | Status word |
| ctrl_word | output | 16 | Control word |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The hardest situations to reach are collisions: a flag-setting event in the same cycle as the read that would clear it, and an interrupt-setting transition in the same cycle as each kind of clear. Directed sequences line these strobes up on the same edge. A ring edge arriving while the control word holds the block in reset is also hard to reach. It only shows up through the two synchronizer edges, so the stimulus first writes the reset bit, then toggles the pin and samples after each edge. A long pseudo-random phase then mixes all strobes, mode changes and rare control writes, and a behavioural model is compared against the outputs on every clock.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int STAT_W = 16;
    localparam int CTRL_W = 16;

    // status bit positions
    localparam int ST_IRQ  = 15;
    localparam int ST_RING = 14;
    localparam int ST_RDY  = 6;
    localparam int ST_OVR  = 5;
    localparam int ST_ERR  = 4;
    localparam int ST_B3   = 3;
    localparam int ST_B2   = 2;
    localparam int ST_B1   = 1;

    // control bit positions
    localparam int CT_MSK_RDY  = 0;
    localparam int CT_MSK_OVR  = 1;
    localparam int CT_RING_EN  = 5;
    localparam int CT_IRQ_OE   = 6;
    localparam int CT_HOLD_RST = 7;
    localparam int CT_PWRSAVE  = 8;

    typedef struct packed {
        logic ready;
        logic overrun;
        logic error;
        logic eop;
        logic par1_even;
        logic par2_even;
        logic two_char;
    } rx_evt_t;

    typedef struct packed {
        logic rdy;
        logic ovr;
        logic err;
        logic b3;
        logic b2;
        logic b1;
    } rx_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic      irq,
        input logic      ring,
        input rx_flags_t f
    );
        logic [STAT_W-1:0] w;
        w          = '0;
        w[ST_IRQ]  = irq;
        w[ST_RING] = ring;
        w[ST_RDY]  = f.rdy;
        w[ST_OVR]  = f.ovr;
        w[ST_ERR]  = f.err;
        w[ST_B3]   = f.b3;
        w[ST_B2]   = f.b2;
        w[ST_B1]   = f.b1;
        return w;
    endfunction

    // which status bits may raise the interrupt on a 0-to-1 transition
    function automatic logic [STAT_W-1:0] irq_enable_vec(input logic [CTRL_W-1:0] c);
        logic [STAT_W-1:0] m;
        m          = '0;
        m[ST_RDY]  = c[CT_MSK_RDY];
        m[ST_OVR]  = c[CT_MSK_OVR];
        m[ST_RING] = c[CT_RING_EN] & c[CT_IRQ_OE];
        return m;
    endfunction

    function automatic logic holds_block(input logic [CTRL_W-1:0] c);
        return c[CT_HOLD_RST] | c[CT_PWRSAVE];
    endfunction

endpackage

// File: rtl/ms_ring_sync.sv
module ms_ring_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic ring_now,
    output logic ring_next
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pin_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign ring_now  = ~chain[STAGES-1];
    assign ring_next = ~chain[STAGES-2];
endmodule

// File: rtl/ms_ctrl_reg.sv
module ms_ctrl_reg
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_reset,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              wr_irq_clear
);
    always_ff @(posedge clk) begin
        if (rst || cmd_reset) ctrl_q <= '0;
        else if (we)          ctrl_q <= wdata;
    end

    assign wr_irq_clear = we & (wdata[CT_HOLD_RST] | wdata[CT_PWRSAVE]);
endmodule

// File: rtl/ms_rx_flags.sv
module ms_rx_flags
    import mstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  logic      hdlc_mode,
    input  rx_evt_t   evt,
    input  logic      stat_rd,
    input  logic      rxd_rd,
    output rx_flags_t flags_q,
    output rx_flags_t flags_d
);
    always_comb begin
        flags_d     = flags_q;
        flags_d.rdy = evt.ready   | (flags_q.rdy & ~rxd_rd);
        flags_d.ovr = evt.overrun | (flags_q.ovr & ~rxd_rd);
        flags_d.err = evt.error   | (flags_q.err & ~stat_rd);
        if (hdlc_mode) begin
            flags_d.b3 = evt.eop | (flags_q.b3 & ~rxd_rd);
            flags_d.b2 = 1'b0;
            flags_d.b1 = 1'b0;
        end else if (evt.ready) begin
            flags_d.b3 = evt.par1_even;
            flags_d.b2 = evt.par2_even & evt.two_char;
            flags_d.b1 = evt.two_char;
        end
        if (hold) flags_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end
endmodule

// File: rtl/ms_irq_latch.sv
module ms_irq_latch
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_cur,
    input  logic [STAT_W-1:0] stat_nxt,
    input  logic [STAT_W-1:0] enable_vec,
    input  logic              force_clr,
    input  logic              rd_clr,
    output logic              irq_q
);
    logic [STAT_W-1:0] rising;
    logic              set_irq;
    logic              irq_d;

    assign rising  = stat_nxt & ~stat_cur;
    assign set_irq = |(rising & enable_vec);

    always_comb begin
        irq_d = irq_q;
        if (force_clr)    irq_d = 1'b0;
        else if (set_irq) irq_d = 1'b1;
        else if (rd_clr)  irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq
    import mstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ring_det_n,
    input  logic        hdlc_mode,
    input  logic        ev_ready,
    input  logic        ev_overrun,
    input  logic        ev_error,
    input  logic        ev_eop,
    input  logic        par1_even,
    input  logic        par2_even,
    input  logic        two_char,
    input  logic        stat_rd,
    input  logic        rxd_rd,
    input  logic        ctrl_we,
    input  logic [15:0] ctrl_wdata,
    input  logic        cmd_reset,
    output logic [15:0] stat_word,
    output logic [15:0] ctrl_word,
    output logic        irq_n
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              wr_irq_clear;
    logic              ring_now;
    logic              ring_next;
    rx_evt_t           evt;
    rx_flags_t         flags_q;
    rx_flags_t         flags_d;
    logic              irq_q;
    logic [STAT_W-1:0] stat_cur;
    logic [STAT_W-1:0] stat_nxt;

    assign evt = '{ready:     ev_ready,
                   overrun:   ev_overrun,
                   error:     ev_error,
                   eop:       ev_eop,
                   par1_even: par1_even,
                   par2_even: par2_even,
                   two_char:  two_char};

    ms_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_reset    (cmd_reset),
        .we           (ctrl_we),
        .wdata        (ctrl_wdata),
        .ctrl_q       (ctrl_q),
        .wr_irq_clear (wr_irq_clear)
    );

    ms_ring_sync #(.STAGES(SYNC_STAGES)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ring_det_n),
        .ring_now  (ring_now),
        .ring_next (ring_next)
    );

    ms_rx_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .hold      (holds_block(ctrl_q) | cmd_reset),
        .hdlc_mode (hdlc_mode),
        .evt       (evt),
        .stat_rd   (stat_rd),
        .rxd_rd    (rxd_rd),
        .flags_q   (flags_q),
        .flags_d   (flags_d)
    );

    assign stat_cur = pack_status(irq_q, ring_now, flags_q);
    assign stat_nxt = pack_status(1'b0, ring_next, flags_d);

    ms_irq_latch u_irq (
        .clk        (clk),
        .rst        (rst),
        .stat_cur   (stat_cur),
        .stat_nxt   (stat_nxt),
        .enable_vec (irq_enable_vec(ctrl_q)),
        .force_clr  (cmd_reset | wr_irq_clear),
        .rd_clr     (stat_rd),
        .irq_q      (irq_q)
    );

    assign stat_word = stat_cur;
    assign ctrl_word = ctrl_q;
    assign irq_n     = ~(irq_q & ctrl_q[CT_IRQ_OE]);
endmodule

// File: rtl/modem_status_irq_chk.sv
module modem_status_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        hdlc_mode,
    input logic        ev_ready,
    input logic        ctrl_we,
    input logic [15:0] ctrl_wdata,
    input logic        cmd_reset,
    input logic [15:0] stat_word,
    input logic [15:0] ctrl_word,
    input logic        irq_n
);
    // R2: a ready event outside hold sets bit 6
    a_r2_ready_sets: assert property (@(posedge clk) disable iff (rst)
        (ev_ready && !ctrl_word[7] && !ctrl_word[8] && !cmd_reset) |=> stat_word[6]);

    // R6: packet mode keeps bits 2 and 1 at zero
    a_r6_hdlc_low_bits: assert property (@(posedge clk) disable iff (rst)
        hdlc_mode |=> (stat_word[2:1] == 2'b00));

    // R7: IRQ rises only together with a masked rising status bit
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[15]) |->
            (($rose(stat_word[6])  && $past(ctrl_word[0])) ||
             ($rose(stat_word[5])  && $past(ctrl_word[1])) ||
             ($rose(stat_word[14]) && $past(ctrl_word[5]) && $past(ctrl_word[6]))));

    // R8: control write with reset or powersave bit clears IRQ
    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && (ctrl_wdata[7] || ctrl_wdata[8]) && !cmd_reset) |=> !stat_word[15]);

    // R12: general reset command clears control word and IRQ
    a_r12_cmd_reset: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (ctrl_word == 16'h0000) && !stat_word[15]);

    // R9: the pin falls only when IRQ or its enable rises
    a_r9_pin_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($rose(stat_word[15]) || $rose(ctrl_word[6])));

    // R11: hold bits empty the receive flags
    a_r11_hold_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[7] || ctrl_word[8]) |=> (stat_word[6:1] == 6'b0));
endmodule

bind modem_status_irq modem_status_irq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .hdlc_mode  (hdlc_mode),
    .ev_ready   (ev_ready),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .cmd_reset  (cmd_reset),
    .stat_word  (stat_word),
    .ctrl_word  (ctrl_word),
    .irq_n      (irq_n)
);

// File: tb/test_modem_status_irq.sv
module test_modem_status_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ring_det_n = 1'b1;
    logic        hdlc_mode = 1'b0;
    logic        ev_ready = 1'b0, ev_overrun = 1'b0, ev_error = 1'b0, ev_eop = 1'b0;
    logic        par1_even = 1'b0, par2_even = 1'b0, two_char = 1'b0;
    logic        stat_rd = 1'b0, rxd_rd = 1'b0, ctrl_we = 1'b0, cmd_reset = 1'b0;
    logic [15:0] ctrl_wdata = 16'h0;
    logic [15:0] stat_word, ctrl_word;
    logic        irq_n;

    int vectors = 0;
    int misses  = 0;
    bit armed   = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    modem_status_irq i_modem_status_irq (.*);

    // ---------------- behavioural reference ----------------
    bit       m_irq, m_rdy, m_ovr, m_err, m_b3, m_b2, m_b1;
    bit [15:0] m_ctrl;
    bit       sync_q[$];   // sync_q[0] nearest the pin

    always @(posedge clk) begin
        bit ring_old, ring_new, hold, n_rdy, n_ovr, n_err, n_b3, n_b2, n_b1, rise;
        if (rst) begin
            {m_irq, m_rdy, m_ovr, m_err, m_b3, m_b2, m_b1} = '0;
            m_ctrl = '0;
            sync_q = '{1'b1, 1'b1};
        end else begin
            ring_old = !sync_q[1];
            ring_new = !sync_q[0];
            hold  = m_ctrl[7] || m_ctrl[8] || cmd_reset;
            n_rdy = ev_ready   || (m_rdy && !rxd_rd);
            n_ovr = ev_overrun || (m_ovr && !rxd_rd);
            n_err = ev_error   || (m_err && !stat_rd);
            n_b3 = m_b3; n_b2 = m_b2; n_b1 = m_b1;
            if (hdlc_mode) begin
                n_b3 = ev_eop || (m_b3 && !rxd_rd);
                n_b2 = 0; n_b1 = 0;
            end else if (ev_ready) begin
                n_b3 = par1_even; n_b2 = par2_even && two_char; n_b1 = two_char;
            end
            if (hold) {n_rdy, n_ovr, n_err, n_b3, n_b2, n_b1} = '0;
            rise = (n_rdy && !m_rdy && m_ctrl[0]) || (n_ovr && !m_ovr && m_ctrl[1]) ||
                   (ring_new && !ring_old && m_ctrl[5] && m_ctrl[6]);
            if (cmd_reset || (ctrl_we && (ctrl_wdata[7] || ctrl_wdata[8]))) m_irq = 0;
            else if (rise)    m_irq = 1;
            else if (stat_rd) m_irq = 0;
            {m_rdy, m_ovr, m_err, m_b3, m_b2, m_b1} = {n_rdy, n_ovr, n_err, n_b3, n_b2, n_b1};
            if (cmd_reset)    m_ctrl = '0;
            else if (ctrl_we) m_ctrl = ctrl_wdata;
            void'(sync_q.pop_back());
            sync_q.push_front(ring_det_n);
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst) begin
            check("R2 ready bit",   {15'b0, stat_word[6]},  {15'b0, m_rdy});
            check("R3 overrun bit", {15'b0, stat_word[5]},  {15'b0, m_ovr});
            check("R4 error bit",   {15'b0, stat_word[4]},  {15'b0, m_err});
            if (hdlc_mode) check("R6 packet bits", {13'b0, stat_word[3:1]}, {13'b0, m_b3, m_b2, m_b1});
            else           check("R5 char bits",   {13'b0, stat_word[3:1]}, {13'b0, m_b3, m_b2, m_b1});
            check("R7 irq bit",     {15'b0, stat_word[15]}, {15'b0, m_irq});
            check("R10 ring bit",   {15'b0, stat_word[14]}, {15'b0, !sync_q[1]});
            check("R9 irq pin",     {15'b0, irq_n},         {15'b0, !(m_irq && m_ctrl[6])});
            check("R12 control",    ctrl_word,              m_ctrl);
            check("R13 reserved",   {stat_word[13:7], stat_word[0]}, 16'h0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulses();
        {ev_ready, ev_overrun, ev_error, ev_eop, stat_rd, rxd_rd, ctrl_we, cmd_reset} = '0;
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_wdata = v; ctrl_we = 1; tick(); clear_pulses();
    endtask

    task automatic pulse_sync();
        tick(); clear_pulses();
    endtask

    task automatic expect_stat(input string req, input logic [15:0] exp);
        check(req, stat_word, exp);
    endtask

    // ---------------- directed and random sequences ----------------
    initial begin
        tick(3);
        rst = 0;
        armed = 1;
        // R1 reset state
        check("R1 status after reset", stat_word, 16'h0000);
        check("R1 control after reset", ctrl_word, 16'h0000);
        check("R1 pin after reset", {15'b0, irq_n}, 16'h0001);

        wr_ctrl(16'h0063);
        ev_ready = 1; pulse_sync();
        expect_stat("R7 ready raises irq", 16'h8040);
        check("R9 pin low", {15'b0, irq_n}, 16'h0000);
        stat_rd = 1; pulse_sync();
        expect_stat("R8 status read clears irq", 16'h0040);
        // R13: a read strobe leaves the word unchanged until the edge
        stat_rd = 1; #1 check("R13 pre-clear value", stat_word, 16'h0040); pulse_sync();
        rxd_rd = 1; ev_ready = 1; pulse_sync();
        expect_stat("R2 event beats read", 16'h0040);
        rxd_rd = 1; pulse_sync();
        expect_stat("R2 read clears ready", 16'h0000);
        ev_overrun = 1; pulse_sync();
        expect_stat("R3 overrun raises irq", 16'h8020);
        stat_rd = 1; pulse_sync();
        rxd_rd = 1; pulse_sync();
        expect_stat("R3 read clears overrun", 16'h0000);
        ev_error = 1; pulse_sync();
        expect_stat("R4 error sets without irq", 16'h0010);
        ev_error = 1; stat_rd = 1; pulse_sync();
        expect_stat("R4 event beats read", 16'h0010);
        stat_rd = 1; pulse_sync();
        expect_stat("R4 read clears error", 16'h0000);

        // start-stop parity
        ev_ready = 1; two_char = 1; par1_even = 1; par2_even = 1; pulse_sync();
        expect_stat("R5 two chars even", 16'h804E);
        stat_rd = 1; pulse_sync();
        rxd_rd = 1; pulse_sync();
        expect_stat("R5 bits held after read", 16'h000E);
        ev_ready = 1; two_char = 0; par1_even = 0; par2_even = 1; pulse_sync();
        expect_stat("R5 single odd char", 16'h8040);
        stat_rd = 1; rxd_rd = 1; pulse_sync();
        expect_stat("R5 cleared", 16'h0000);

        // packet mode
        hdlc_mode = 1; tick();
        ev_eop = 1; pulse_sync();
        expect_stat("R6 end of packet", 16'h0008);
        rxd_rd = 1; pulse_sync();
        expect_stat("R6 read clears eop", 16'h0000);
        hdlc_mode = 0; tick();

        // ring with interrupt
        ring_det_n = 0; tick();
        expect_stat("R10 one edge not yet", 16'h0000);
        tick();
        expect_stat("R10 ring seen with irq", 16'hC000);
        stat_rd = 1; pulse_sync();
        ring_det_n = 1; tick(2);
        expect_stat("R10 ring released", 16'h0000);

        // ring mask without pin enable
        wr_ctrl(16'h0020);
        ring_det_n = 0; tick(2);
        expect_stat("R7 ring needs both bits", 16'h4000);
        ring_det_n = 1; tick(2);

        // reset bit in control
        wr_ctrl(16'h0063);
        ev_ready = 1; pulse_sync();
        wr_ctrl(16'h00E3);
        expect_stat("R8 reset write clears irq", 16'h0040);
        tick();
        expect_stat("R11 hold clears flags", 16'h0000);
        ev_ready = 1; ev_error = 1; pulse_sync();
        expect_stat("R11 events ignored", 16'h0000);
        ring_det_n = 0; tick(2);
        expect_stat("R10 ring works in reset", 16'hC000);
        stat_rd = 1; ring_det_n = 1; pulse_sync(); tick();

        // powersave
        wr_ctrl(16'h0163);
        ev_overrun = 1; pulse_sync();
        expect_stat("R11 powersave ignores", 16'h0000);

        // general reset command
        wr_ctrl(16'h0063);
        ring_det_n = 0; tick(2);
        stat_rd = 1; pulse_sync();
        ev_ready = 1; pulse_sync();
        expect_stat("R7 ready irq before cmd", 16'hC040);
        cmd_reset = 1; ev_ready = 1; ctrl_we = 1; ctrl_wdata = 16'h0063; pulse_sync();
        expect_stat("R12 cmd reset keeps ring", 16'h4000);
        check("R12 cmd reset clears control", ctrl_word, 16'h0000);
        ring_det_n = 1; tick(2);

        // pseudo-random mix against the reference
        for (int i = 0; i < 4000; i++) begin
            ev_ready   = ($urandom % 6) == 0;
            ev_overrun = ($urandom % 12) == 0;
            ev_error   = ($urandom % 12) == 0;
            ev_eop     = ($urandom % 10) == 0;
            par1_even  = $urandom % 2;
            par2_even  = $urandom % 2;
            two_char   = $urandom % 2;
            stat_rd    = ($urandom % 5) == 0;
            rxd_rd     = ($urandom % 5) == 0;
            cmd_reset  = ($urandom % 80) == 0;
            ctrl_we    = ($urandom % 20) == 0;
            ctrl_wdata = 16'h0063 | (($urandom % 4) == 0 ? 16'h0080 : 16'h0)
                                  | (($urandom % 6) == 0 ? 16'h0100 : 16'h0)
                                  & ~(($urandom % 3) == 0 ? 16'h0040 : 16'h0);
            if (($urandom % 9) == 0) ring_det_n = ~ring_det_n;
            if (($urandom % 60) == 0) hdlc_mode = ~hdlc_mode;
            tick();
        end
        clear_pulses();
        tick(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule